// File: doc/BRIEF.md
# Work-Unit Command Guard

This block sits between a peripheral and one channel of a DMA engine that writes into memory. The peripheral can end the channel's current work unit early by asking for a restart or a finish command. Such a command is only safe once the previous work unit has fully drained out of the channel's buffer. The guard proves this by counting the data grants seen in the current work unit. If the previous unit was closed by a plain restart or ended on its own, it waits for five grants. If the previous unit was closed by a finish, one grant is enough.

A request that is not yet safe is held pending, with `busy` raised. It goes to the channel in the first cycle it becomes safe, and exactly once. The block also tracks the programmed row length and row count, so that it can see when a work unit ends on its own after X*Y grants. A programmed count of zero means 65,536.

The command encoding is 0 for restart and 1 for finish, on both `req_kind` and `issue_kind`.

Top module: `wu_cmd_guard`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block drops any pending request, clears its grant count and clears its finish memory. Afterwards `busy` and `issue_valid` are 0, and the five-grant rule applies.
- R2: When the previous work unit was not closed by a finish, a command is issued only once at least five grants of the current unit were registered at earlier edges.
- R3: When the previous work unit was closed by a finish (`issue_kind`=1), one registered grant in the current unit is enough to issue a command.
- R4: A request that is not yet allowed raises `busy` from the next cycle. `issue_valid` pulses, with the requested kind, in the first cycle the grant count allows it, and `busy` falls in the cycle after.
- R5: Each accepted request produces exactly one issue. A `req_valid` asserted while `busy` is high is ignored.
- R6: A `req_valid` with `chan_mem_wr` low is ignored: there is no issue and `busy` stays 0.
- R7: An issue starts a new work unit and clears the grant count, which saturates at five. A grant in the same cycle as the issue counts toward the new unit.
- R8: After X*Y grants in one unit, `unit_end` pulses in the cycle of the last grant. This clears the grant count and the finish memory.
- R9: A programmed X or Y count of 0 stands for 65,536, so with X=0 and Y=1 `unit_end` pulses on the 65,536th grant and not before.
- R10: Issuing a restart clears the finish memory, so the next unit again needs five grants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_mem_wr | input | 1 | Channel is set up for memory write |
| grant | input | 1 | One data transfer granted this cycle |
| req_valid | input | 1 | Peripheral asks for a command |
| req_kind | input | 1 | Requested command: 0 restart, 1 finish |
| x_count | input | XY_W | Items per row (0 means 2^XY_W) |
| y_count | input | XY_W | Rows per unit (0 means 2^XY_W) |
| issue_valid | output | 1 | Command is sent to the channel this cycle |
| issue_kind | output | 1 | Kind of the command sent: 0 restart, 1 finish |
| busy | output | 1 | A request is held pending |
| unit_end | output | 1 | This cycle's grant completes the unit on its own |

## Verification
`issue_valid` and `unit_end` are combinational on registered state. `issue_valid` is due in the request's own cycle if the count already allows it; otherwise it is due in the cycle after the rising edge that registers the deciding grant. `unit_end` is due in the cycle of the final grant. `busy` rises one edge after an unaccepted request and falls one edge after the issue. The bench drives inputs at the falling edge and samples one time unit later, so each check reads the cycle the result is due in.

// File: rtl/wu_guard_pkg.sv
// Package: shared command type and default thresholds for the work-unit
// command guard. Assumes one command kind bit: restart or finish.
package wu_guard_pkg;

    typedef enum logic {
        CMD_RESTART = 1'b0,
        CMD_FINISH  = 1'b1
    } wu_cmd_e;

    // Grants needed when the previous unit was not finish-terminated.
    localparam int unsigned STRICT_MIN_DEF = 5;
    // Grants needed after a finish-terminated unit.
    localparam int unsigned RELAX_MIN_DEF  = 1;

endpackage

// File: rtl/wu_grant_tally.sv
// Module: wu_grant_tally
// Counts the data grants in the current work unit and saturates at MAX_CNT.
// Assumes new_unit marks an issued command. A grant in that same cycle
// belongs to the new unit. unit_end marks a natural end of the unit.
module wu_grant_tally #(
    parameter int unsigned MAX_CNT = 5,
    localparam int unsigned CW = $clog2(MAX_CNT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          grant,
    input  logic          new_unit,
    input  logic          unit_end,
    output logic [CW-1:0] cnt
);

    // Per-unit grant count with restart, clear and saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (unit_end) begin
            cnt <= '0;
        end else if (new_unit) begin
            cnt <= grant ? CW'(1) : '0;
        end else if (grant && (cnt != CW'(MAX_CNT))) begin
            cnt <= cnt + CW'(1);
        end
    end

    AST_TALLY_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(MAX_CNT)); // R7
    AST_TALLY_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (new_unit && !unit_end) |=> (cnt == ($past(grant) ? CW'(1) : CW'(0)))); // R7
    AST_TALLY_END: assert property (@(posedge clk) disable iff (!rst_n)
        unit_end |=> (cnt == '0)); // R8

endmodule

// File: rtl/wu_geom_track.sv
// Module: wu_geom_track
// Follows the row and column position inside a work unit. It flags the grant
// that completes X*Y items. A programmed count of zero stands for 2^XY_W.
// Assumes the counts change only between work units.
module wu_geom_track #(
    parameter int unsigned XY_W = 16,
    localparam int unsigned LW = XY_W + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            grant,
    input  logic            new_unit,
    input  logic [XY_W-1:0] x_count,
    input  logic [XY_W-1:0] y_count,
    output logic            unit_end
);

    logic [LW-1:0] x_lim, y_lim;
    logic [LW-1:0] x_idx, y_idx;
    logic [LW-1:0] x_base, y_base;
    logic [LW-1:0] x_nxt, y_nxt;
    logic          x_last, y_last;

    // Effective limits: zero selects the largest count.
    always_comb begin
        x_lim = (x_count == '0) ? {1'b1, {XY_W{1'b0}}} : {1'b0, x_count};
        y_lim = (y_count == '0) ? {1'b1, {XY_W{1'b0}}} : {1'b0, y_count};
    end

    // Position the grant applies to: an issued command restarts at zero.
    always_comb begin
        x_base   = new_unit ? '0 : x_idx;
        y_base   = new_unit ? '0 : y_idx;
        x_last   = (x_base == x_lim - LW'(1));
        y_last   = (y_base == y_lim - LW'(1));
        unit_end = grant && x_last && y_last;
    end

    // Next position after this cycle's grant, wrapping at row and unit end.
    always_comb begin
        x_nxt = x_base;
        y_nxt = y_base;
        if (grant) begin
            if (x_last) begin
                x_nxt = '0;
                y_nxt = y_last ? '0 : y_base + LW'(1);
            end else begin
                x_nxt = x_base + LW'(1);
            end
        end
    end

    // Position registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_idx <= '0;
            y_idx <= '0;
        end else begin
            x_idx <= x_nxt;
            y_idx <= y_nxt;
        end
    end

    AST_END_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        unit_end |-> grant); // R8
    AST_END_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        unit_end |=> (x_idx == '0 && y_idx == '0)); // R8
    AST_NEW_UNIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (new_unit && !grant) |=> (x_idx == '0 && y_idx == '0)); // R7

endmodule

// File: rtl/wu_cmd_gate.sv
// Module: wu_cmd_gate
// Holds a command request until the grant count proves the previous unit
// has drained, then issues it once. Remembers whether the last unit ended
// by a finish. Assumes cnt comes from wu_grant_tally, registered.
module wu_cmd_gate
    import wu_guard_pkg::*;
#(
    parameter int unsigned STRICT_MIN = 5,
    parameter int unsigned RELAX_MIN  = 1,
    parameter int unsigned CW         = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mem_wr,
    input  logic          req_valid,
    input  wu_cmd_e       req_kind,
    input  logic [CW-1:0] cnt,
    input  logic          unit_end,
    output logic          issue_valid,
    output wu_cmd_e       issue_kind,
    output logic          busy
);

    logic    pend;
    wu_cmd_e pend_kind;
    logic    fin_flag;
    logic    allowed;
    logic    new_req;

    // Safety test and choice between a held request and a new one.
    always_comb begin
        allowed     = (cnt >= CW'(STRICT_MIN)) || (fin_flag && (cnt >= CW'(RELAX_MIN)));
        new_req     = req_valid && mem_wr && !pend;
        issue_kind  = pend ? pend_kind : req_kind;
        issue_valid = (pend || new_req) && allowed;
        busy        = pend;
    end

    // Pending request register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend      <= 1'b0;
            pend_kind <= CMD_RESTART;
        end else if (issue_valid) begin
            pend <= 1'b0;
        end else if (new_req) begin
            pend      <= 1'b1;
            pend_kind <= req_kind;
        end
    end

    // Memory of how the previous work unit ended.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fin_flag <= 1'b0;
        end else if (unit_end) begin
            fin_flag <= 1'b0;
        end else if (issue_valid) begin
            fin_flag <= (issue_kind == CMD_FINISH);
        end
    end

    AST_STRICT_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !fin_flag) |-> (cnt >= CW'(STRICT_MIN))); // R2
    AST_RELAX_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (cnt >= CW'(RELAX_MIN))); // R3
    AST_FIN_REMEMBERED: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_kind == CMD_FINISH && !unit_end) |=> fin_flag); // R3
    AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !issue_valid) |=> (busy && $stable(issue_kind))); // R4
    AST_ONE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |=> !busy); // R5
    AST_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_wr && !busy) |-> !issue_valid); // R6
    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_kind == CMD_RESTART) |=> !fin_flag); // R10

endmodule

// File: rtl/wu_cmd_guard.sv
// Module: wu_cmd_guard (top)
// Guards restart/finish commands from a peripheral to a memory-write DMA
// channel. Assumes one grant per cycle at most and counts that change only
// between work units. Reset is synchronous, active low.
module wu_cmd_guard
    import wu_guard_pkg::*;
#(
    parameter int unsigned XY_W       = 16,
    parameter int unsigned STRICT_MIN = STRICT_MIN_DEF,
    parameter int unsigned RELAX_MIN  = RELAX_MIN_DEF,
    localparam int unsigned CW = $clog2(STRICT_MIN + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            chan_mem_wr,
    input  logic            grant,
    input  logic            req_valid,
    input  logic            req_kind,
    input  logic [XY_W-1:0] x_count,
    input  logic [XY_W-1:0] y_count,
    output logic            issue_valid,
    output logic            issue_kind,
    output logic            busy,
    output logic            unit_end
);

    logic [CW-1:0] cnt;
    wu_cmd_e       kind_out;

    wu_grant_tally #(.MAX_CNT(STRICT_MIN)) u_tally (
        .clk      (clk),
        .rst_n    (rst_n),
        .grant    (grant),
        .new_unit (issue_valid),
        .unit_end (unit_end),
        .cnt      (cnt)
    );

    wu_geom_track #(.XY_W(XY_W)) u_geom (
        .clk      (clk),
        .rst_n    (rst_n),
        .grant    (grant),
        .new_unit (issue_valid),
        .x_count  (x_count),
        .y_count  (y_count),
        .unit_end (unit_end)
    );

    wu_cmd_gate #(
        .STRICT_MIN (STRICT_MIN),
        .RELAX_MIN  (RELAX_MIN),
        .CW         (CW)
    ) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .mem_wr      (chan_mem_wr),
        .req_valid   (req_valid),
        .req_kind    (wu_cmd_e'(req_kind)),
        .cnt         (cnt),
        .unit_end    (unit_end),
        .issue_valid (issue_valid),
        .issue_kind  (kind_out),
        .busy        (busy)
    );

    assign issue_kind = logic'(kind_out);

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!busy && cnt == '0)); // R1

endmodule

// File: tb/sim_wu_cmd_guard.sv
module sim_wu_cmd_guard;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;
    // Per row: grants before the request, kind, extra grants expected.
    localparam int V_PRE [NV]   = '{0, 2, 0, 7, 1, 0, 4, 3};
    localparam int V_KIND [NV]  = '{0, 1, 0, 1, 1, 1, 0, 0};
    localparam int V_EXTRA [NV] = '{5, 3, 1, 0, 0, 1, 0, 2};

    logic clk = 1'b0, rst_n = 1'b0, chan_mem_wr = 1'b1, grant = 1'b0;
    logic req_valid = 1'b0, req_kind = 1'b0;
    logic [15:0] x_count = '0, y_count = '0;
    logic issue_valid, issue_kind, busy, unit_end;
    int n_run = 0, n_fail = 0;

    wu_cmd_guard u0 (.clk(clk), .rst_n(rst_n), .chan_mem_wr(chan_mem_wr), .grant(grant),
        .req_valid(req_valid), .req_kind(req_kind), .x_count(x_count), .y_count(y_count),
        .issue_valid(issue_valid), .issue_kind(issue_kind), .busy(busy), .unit_end(unit_end));

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic give(input int n);
        for (int i = 0; i < n; i++) begin
            grant = 1'b1;
            tick();
            grant = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int extra, issues, ends;
        @(negedge clk); tick(); tick();
        #1 chk("R1 busy in reset", busy, 0);
        rst_n = 1'b1;
        tick();
        #1 chk("R1 issue after reset", issue_valid, 0);

        // Vector table: R2, R3, R4, R10 (row 8 follows a restart after a finish).
        for (int v = 0; v < NV; v++) begin
            give(V_PRE[v]);
            req_valid = 1'b1; req_kind = V_KIND[v][0];
            #1;
            if (V_EXTRA[v] == 0) begin
                chk("R3 immediate issue", issue_valid, 1);
                chk("R4 kind", issue_kind, V_KIND[v]);
            end else begin
                chk("R2 held back", issue_valid, 0);
            end
            tick();
            req_valid = 1'b0;
            if (V_EXTRA[v] != 0) begin
                #1 chk("R4 busy while held", busy, 1);
                extra = 0;
                while (!issue_valid && extra < 10) begin
                    grant = 1'b1; tick(); grant = 1'b0; extra++;
                    #1;
                end
                chk("R2 R3 R10 grants needed", extra, V_EXTRA[v]);
                chk("R4 kind", issue_kind, V_KIND[v]);
                tick();
            end
            #1 chk("R4 busy cleared", busy, 0);
        end

        // R5: a second request while busy is ignored.
        give(2);
        req_valid = 1'b1; req_kind = 1'b0; tick();
        req_kind = 1'b1; tick();
        req_valid = 1'b0;
        issues = 0;
        for (int i = 0; i < 12; i++) begin
            grant = (i < 8);
            #1 if (issue_valid) begin
                issues++;
                chk("R5 kind of the single issue", issue_kind, 0);
            end
            tick();
        end
        grant = 1'b0;
        chk("R5 one issue per request", issues, 1);

        // R6: requests ignored when the channel is not in memory-write mode.
        chan_mem_wr = 1'b0;
        req_valid = 1'b1; req_kind = 1'b1;
        #1 chk("R6 no issue", issue_valid, 0);
        tick(); req_valid = 1'b0;
        #1 chk("R6 not busy", busy, 0);
        tick();
        #1 chk("R6 still no issue", issue_valid, 0);
        chan_mem_wr = 1'b1;

        // R7: a grant in the issue cycle counts toward the new unit.
        req_valid = 1'b1; req_kind = 1'b0; grant = 1'b1;
        #1 chk("R7 issue with grant", issue_valid, 1);
        tick(); req_valid = 1'b0; grant = 1'b0;
        give(3);
        req_valid = 1'b1;
        #1 chk("R7 four grants short", issue_valid, 0);
        tick(); req_valid = 1'b0;
        give(1);
        #1 chk("R7 fifth grant incl. issue cycle", issue_valid, 1);
        tick();

        // R8: natural end after X*Y grants clears the count and the finish memory.
        x_count = 16'd3; y_count = 16'd2;
        give(5);
        req_valid = 1'b1; req_kind = 1'b1;
        #1 chk("R8 setup finish", issue_valid, 1);
        tick(); req_valid = 1'b0;
        for (int i = 0; i < 6; i++) begin
            grant = 1'b1;
            #1 chk("R8 unit_end timing", unit_end, (i == 5) ? 1 : 0);
            tick(); grant = 1'b0;
        end
        give(1);
        req_valid = 1'b1; req_kind = 1'b0;
        #1 chk("R8 finish memory cleared", issue_valid, 0);
        tick(); req_valid = 1'b0;
        give(4);
        #1 chk("R8 count cleared, five needed", issue_valid, 1);
        tick();

        // R9: a zero count stands for 65536.
        x_count = 16'd0; y_count = 16'd1;
        ends = 0;
        for (int i = 0; i < 65536; i++) begin
            grant = 1'b1;
            #1 if (i < 65535 && unit_end) ends++;
            if (i == 65535) chk("R9 end on grant 65536", unit_end, 1);
            tick();
        end
        grant = 1'b0;
        chk("R9 no early end", ends, 0);

        // R1: reset drops a pending request and the finish memory.
        x_count = 16'd0; y_count = 16'd0;
        give(5);
        req_valid = 1'b1; req_kind = 1'b1;
        #1 chk("R1 setup finish", issue_valid, 1);
        tick(); req_kind = 1'b0; tick(); req_valid = 1'b0;
        #1 chk("R1 setup pending", busy, 1);
        rst_n = 1'b0; tick(); rst_n = 1'b1;
        #1 chk("R1 pending dropped", busy, 0);
        give(1);
        #1 chk("R1 no stale issue", issue_valid, 0);
        req_valid = 1'b1;
        #1 chk("R1 five-grant rule after reset", issue_valid, 0);
        tick(); req_valid = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule